// File: doc/BRIEF.md
# PCIe Root-Port Link Bring-Up Sequencer

This controller takes a PCIe root-port PHY and its link out of reset once it sees a single start pulse, with no software involved. It first turns on the controller clock. If the serial-management option is selected, it then toggles the serial-management reset and loads eleven PHY registers through a command word. Around these steps it drives the PHY reset word, releases the downstream device reset after holding it low, and pulses the PHY reset a second time. Finally it watches the link-training state input until the link reaches its active code. If the link never gets there, it gives up after a bounded number of tries.

Every delay is a number of milliseconds multiplied by `TICK_CYCLES`, the number of clock cycles in one millisecond. A bench can therefore run the whole sequence with a tick of a few cycles. When the run ends, `done_o` rises together with either `link_up_o` or `timeout_o`. All three flags stay set until the next start, and the controller sits idle until then.

Top module: `link_bringup_seq`

## Requirements
- R1: Reset state: `clk_en_o`=0, `mdio_ctl_o`=0, `phy_rst_o`=0x00, `perst_n_o`=0 (device held in reset), `mdio_wr_o`=0, `mdio_cmd_o`=0, and `done_o`, `link_up_o` and `timeout_o` are all 0.
- R2: In idle, a start pulse sets `clk_en_o` on the next edge and clears all three flags on that same edge. It also samples `mdio_rst_sel_i`. Then follows a wait of `CLK_MS` milliseconds.
- R3: With the option selected, `mdio_ctl_o` next takes 0x8, 0x9 and 0xB on three consecutive cycles. Bit 3 is the enable, bit 0 releases the reset and bit 1 marks the load as done.
- R4: `phy_rst_o` is written 0x01 and then 0x81 on the next cycle. Bit 0 enables link training and bit 7 releases the PHY reset. This happens once after the clock wait (or after the R3 words), followed by a `PHY_MS` wait.
- R5: With the option selected, eleven writes follow, each a one-cycle `mdio_wr_o` strobe with `mdio_cmd_o` = {data[15:0], 3'b0, addr[4:0], 7'b0, 1'b1}. Each write is followed by a `SETTLE_MS` wait. The (address, data) pairs go in this order: (0,5027), (2,6D18), (6,8828), (7,30FF), (8,18D7), (A,00E9), (B,0511), (D,15B6), (F,0F0F), (5,0BCB), (6,8128).
- R6: Without the option, the R3 words and the R5 writes are both skipped.
- R7: `perst_n_o` is driven low for `PERST_MS` and then high. The R4 pair then repeats, followed by a `LINK_MS` wait.
- R8: A poll that finds `ltssm_i[4:0]` == 0x11 sets `done_o` and `link_up_o` one cycle later. Bits above bit 4 are ignored.
- R9: A failed poll waits `POLL_MS` and then polls again. When the `POLL_TRIES`-th poll fails, `done_o` and `timeout_o` are set instead.
- R10: A start pulse while a run is in progress has no effect. The flags hold their values in idle until the next start.
- R11: Each wait of N milliseconds lasts exactly N×`TICK_CYCLES` cycles. Every command state adds exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, acted on only in idle |
| mdio_rst_sel_i | input | 1 | Selects the serial-management reset and PHY preload |
| ltssm_i | input | STATE_W | Link-training state from the controller |
| clk_en_o | output | 1 | Controller clock active |
| mdio_ctl_o | output | 4 | Serial-management reset control word |
| phy_rst_o | output | 8 | PHY reset / training-enable word |
| perst_n_o | output | 1 | Downstream device reset, active low |
| mdio_cmd_o | output | 32 | PHY register write command |
| mdio_wr_o | output | 1 | One-cycle strobe for `mdio_cmd_o` |
| done_o | output | 1 | Run finished |
| link_up_o | output | 1 | Link reached its active state |
| timeout_o | output | 1 | Poll limit reached without link |

## Verification
The bound checker tests on every cycle the local ordering rules:
- the 0x8→0x9→0xB control steps;
- 0x81 always following 0x01;
- single-cycle command strobes with a valid write format;
- link-up only after a matching state code;
- mutually exclusive result flags that always come with `done_o`.

Only the bench scenarios can show the absolute timing of each wait, the order and content of the eleven preload writes, and the skip path when the option is off. The same holds for the retry count before a timeout, a late link-up on a later poll, and a start pulse being ignored mid-run.

// File: rtl/bringup_pkg.sv
package bringup_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WAIT,
        ST_MRST0,
        ST_MRST1,
        ST_MRST2,
        ST_PHYA,
        ST_PHYB,
        ST_LOAD,
        ST_PERST,
        ST_PERST_HI,
        ST_POLL
    } seq_state_e;

    localparam int          PRELOAD_N     = 11;
    localparam logic [4:0]  LINK_ACTIVE   = 5'h11;
    localparam logic [3:0]  MCTL_HOLD     = 4'h8;
    localparam logic [3:0]  MCTL_RELEASE  = 4'h9;
    localparam logic [3:0]  MCTL_LOADED   = 4'hB;
    localparam logic [7:0]  PHY_IN_RESET  = 8'h01;
    localparam logic [7:0]  PHY_RUNNING   = 8'h81;

    function automatic logic [31:0] phy_write_word(logic [4:0] addr, logic [15:0] data);
        return {data, 3'b000, addr, 7'b0000000, 1'b1};
    endfunction

endpackage

// File: rtl/bringup_ms_tick.sv
module bringup_ms_tick #(
    parameter int TICK_CYCLES = 125000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    output logic tick_o
);
    localparam int CNT_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_CYCLES - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = !clr_i && (cnt_q == LAST);
        if (clr_i || cnt_q == LAST) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/bringup_preload_rom.sv
module bringup_preload_rom
    import bringup_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic [IDX_W-1:0] idx_i,
    output logic [31:0]      word_o
);
    always_comb begin
        case (idx_i)
            IDX_W'(0):  word_o = phy_write_word(5'h00, 16'h5027);
            IDX_W'(1):  word_o = phy_write_word(5'h02, 16'h6D18);
            IDX_W'(2):  word_o = phy_write_word(5'h06, 16'h8828);
            IDX_W'(3):  word_o = phy_write_word(5'h07, 16'h30FF);
            IDX_W'(4):  word_o = phy_write_word(5'h08, 16'h18D7);
            IDX_W'(5):  word_o = phy_write_word(5'h0A, 16'h00E9);
            IDX_W'(6):  word_o = phy_write_word(5'h0B, 16'h0511);
            IDX_W'(7):  word_o = phy_write_word(5'h0D, 16'h15B6);
            IDX_W'(8):  word_o = phy_write_word(5'h0F, 16'h0F0F);
            IDX_W'(9):  word_o = phy_write_word(5'h05, 16'h0BCB);
            IDX_W'(10): word_o = phy_write_word(5'h06, 16'h8128);
            default:    word_o = '0;
        endcase
    end
endmodule

// File: rtl/link_bringup_seq.sv
module link_bringup_seq
    import bringup_pkg::*;
#(
    parameter int TICK_CYCLES = 125000,
    parameter int CLK_MS      = 100,
    parameter int PHY_MS      = 100,
    parameter int SETTLE_MS   = 1,
    parameter int PERST_MS    = 300,
    parameter int LINK_MS     = 1100,
    parameter int POLL_MS     = 100,
    parameter int POLL_TRIES  = 100,
    parameter int STATE_W     = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               mdio_rst_sel_i,
    input  logic [STATE_W-1:0] ltssm_i,
    output logic               clk_en_o,
    output logic [3:0]         mdio_ctl_o,
    output logic [7:0]         phy_rst_o,
    output logic               perst_n_o,
    output logic [31:0]        mdio_cmd_o,
    output logic               mdio_wr_o,
    output logic               done_o,
    output logic               link_up_o,
    output logic               timeout_o
);
    localparam int MAX_A  = (CLK_MS > PHY_MS) ? CLK_MS : PHY_MS;
    localparam int MAX_B  = (PERST_MS > LINK_MS) ? PERST_MS : LINK_MS;
    localparam int MAX_C  = (POLL_MS > SETTLE_MS) ? POLL_MS : SETTLE_MS;
    localparam int MAX_AB = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int MAX_MS = (MAX_AB > MAX_C) ? MAX_AB : MAX_C;
    localparam int MS_W   = $clog2(MAX_MS + 1);
    localparam int TRY_W  = $clog2(POLL_TRIES + 1);
    localparam int IDX_W  = $clog2(PRELOAD_N + 1);

    typedef struct packed {
        seq_state_e         st;
        seq_state_e         ret;
        logic [MS_W-1:0]    ms;
        logic [IDX_W-1:0]   idx;
        logic [TRY_W-1:0]   tries;
        logic               second;
        logic               opt;
        logic               clk_en;
        logic [3:0]         mctl;
        logic [7:0]         phy;
        logic               perst_n;
        logic [31:0]        cmd;
        logic               wr;
        logic               done;
        logic               link;
        logic               tmo;
    } seq_regs_t;

    seq_regs_t   d, q;
    logic        load_wait;
    logic        tick;
    logic [31:0] rom_word;

    bringup_ms_tick #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (load_wait),
        .tick_o (tick)
    );

    bringup_preload_rom #(.IDX_W(IDX_W)) u_rom (
        .idx_i  (q.idx),
        .word_o (rom_word)
    );

    always_comb begin
        d         = q;
        d.wr      = 1'b0;
        load_wait = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    d.clk_en  = 1'b1;
                    d.done    = 1'b0;
                    d.link    = 1'b0;
                    d.tmo     = 1'b0;
                    d.opt     = mdio_rst_sel_i;
                    d.second  = 1'b0;
                    d.idx     = '0;
                    d.tries   = '0;
                    d.st      = ST_WAIT;
                    d.ms      = MS_W'(CLK_MS);
                    d.ret     = mdio_rst_sel_i ? ST_MRST0 : ST_PHYA;
                    load_wait = 1'b1;
                end
            end
            ST_WAIT: begin
                if (tick) begin
                    if (q.ms == MS_W'(1)) d.st = q.ret;
                    else                  d.ms = q.ms - 1'b1;
                end
            end
            ST_MRST0: begin
                d.mctl = MCTL_HOLD;
                d.st   = ST_MRST1;
            end
            ST_MRST1: begin
                d.mctl = MCTL_RELEASE;
                d.st   = ST_MRST2;
            end
            ST_MRST2: begin
                d.mctl = MCTL_LOADED;
                d.st   = ST_PHYA;
            end
            ST_PHYA: begin
                d.phy = PHY_IN_RESET;
                d.st  = ST_PHYB;
            end
            ST_PHYB: begin
                d.phy     = PHY_RUNNING;
                d.st      = ST_WAIT;
                load_wait = 1'b1;
                if (q.second) begin
                    d.ms  = MS_W'(LINK_MS);
                    d.ret = ST_POLL;
                end else begin
                    d.ms  = MS_W'(PHY_MS);
                    d.ret = q.opt ? ST_LOAD : ST_PERST;
                end
            end
            ST_LOAD: begin
                d.cmd     = rom_word;
                d.wr      = 1'b1;
                d.idx     = q.idx + 1'b1;
                d.st      = ST_WAIT;
                d.ms      = MS_W'(SETTLE_MS);
                d.ret     = (q.idx == IDX_W'(PRELOAD_N - 1)) ? ST_PERST : ST_LOAD;
                load_wait = 1'b1;
            end
            ST_PERST: begin
                d.perst_n = 1'b0;
                d.st      = ST_WAIT;
                d.ms      = MS_W'(PERST_MS);
                d.ret     = ST_PERST_HI;
                load_wait = 1'b1;
            end
            ST_PERST_HI: begin
                d.perst_n = 1'b1;
                d.second  = 1'b1;
                d.st      = ST_PHYA;
            end
            ST_POLL: begin
                if (ltssm_i[4:0] == LINK_ACTIVE) begin
                    d.done = 1'b1;
                    d.link = 1'b1;
                    d.st   = ST_IDLE;
                end else if (q.tries == TRY_W'(POLL_TRIES - 1)) begin
                    d.done = 1'b1;
                    d.tmo  = 1'b1;
                    d.st   = ST_IDLE;
                end else begin
                    d.tries   = q.tries + 1'b1;
                    d.st      = ST_WAIT;
                    d.ms      = MS_W'(POLL_MS);
                    d.ret     = ST_POLL;
                    load_wait = 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.st  <= ST_IDLE;
            q.ret <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign clk_en_o   = q.clk_en;
    assign mdio_ctl_o = q.mctl;
    assign phy_rst_o  = q.phy;
    assign perst_n_o  = q.perst_n;
    assign mdio_cmd_o = q.cmd;
    assign mdio_wr_o  = q.wr;
    assign done_o     = q.done;
    assign link_up_o  = q.link;
    assign timeout_o  = q.tmo;
endmodule

// File: rtl/link_bringup_chk.sv
module link_bringup_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [4:0]  ltssm_low_i,
    input logic        clk_en_o,
    input logic [3:0]  mdio_ctl_o,
    input logic [7:0]  phy_rst_o,
    input logic        perst_n_o,
    input logic [31:0] mdio_cmd_o,
    input logic        mdio_wr_o,
    input logic        done_o,
    input logic        link_up_o,
    input logic        timeout_o
);
    a_r3_ctl_hold_then_release: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_ctl_o == 4'h8) |=> (mdio_ctl_o == 4'h9));

    a_r3_ctl_release_then_loaded: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_ctl_o == 4'h9) |=> (mdio_ctl_o == 4'hB));

    a_r4_phy_pair: assert property (@(posedge clk) disable iff (!rst_n)
        (phy_rst_o == 8'h01) |=> (phy_rst_o == 8'h81));

    a_r5_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_wr_o |=> !mdio_wr_o);

    a_r5_cmd_format: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_wr_o |-> (mdio_cmd_o[0] && mdio_cmd_o[15:13] == 3'b000 && mdio_cmd_o[7:1] == 7'd0));

    a_r2_clock_before_writes: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_wr_o |-> clk_en_o);

    a_r8_link_needs_code: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(link_up_o) |-> ($past(ltssm_low_i) == 5'h11));

    a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(link_up_o && timeout_o));

    a_r9_result_has_done: assert property (@(posedge clk) disable iff (!rst_n)
        (link_up_o || timeout_o) |-> done_o);

    a_r7_device_out_of_reset_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> (perst_n_o && phy_rst_o == 8'h81));
endmodule

bind link_bringup_seq link_bringup_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ltssm_low_i (ltssm_i[4:0]),
    .clk_en_o    (clk_en_o),
    .mdio_ctl_o  (mdio_ctl_o),
    .phy_rst_o   (phy_rst_o),
    .perst_n_o   (perst_n_o),
    .mdio_cmd_o  (mdio_cmd_o),
    .mdio_wr_o   (mdio_wr_o),
    .done_o      (done_o),
    .link_up_o   (link_up_o),
    .timeout_o   (timeout_o)
);

// File: tb/link_bringup_seq_tb.sv
module link_bringup_seq_tb;
    localparam int T     = 2;
    localparam int TRIES = 100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        sel_i = 1'b0;
    logic [5:0]  ltssm_i = 6'h00;
    logic        clk_en_o, perst_n_o, mdio_wr_o, done_o, link_up_o, timeout_o;
    logic [3:0]  mdio_ctl_o;
    logic [7:0]  phy_rst_o;
    logic [31:0] mdio_cmd_o;

    always #4 clk = ~clk;

    link_bringup_seq #(.TICK_CYCLES(T), .POLL_TRIES(TRIES)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mdio_rst_sel_i(sel_i),
        .ltssm_i(ltssm_i), .clk_en_o(clk_en_o), .mdio_ctl_o(mdio_ctl_o),
        .phy_rst_o(phy_rst_o), .perst_n_o(perst_n_o), .mdio_cmd_o(mdio_cmd_o),
        .mdio_wr_o(mdio_wr_o), .done_o(done_o), .link_up_o(link_up_o),
        .timeout_o(timeout_o)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int base = 0;
    bit mon_en = 0;
    bit finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int          sig;
        logic [31:0] val;
        int          off;
    } ev_t;
    ev_t exp_q[$];
    logic [31:0] model[8];
    logic [31:0] prev[8];

    function automatic string req_of(int s);
        case (s)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3: return "R7";
            4: return "R5";
            5: return "R9";
            6: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
        end
    endtask

    task automatic push(int sig, logic [31:0] val, int off);
        if (sig == 4 || model[sig] !== val) begin
            exp_q.push_back('{sig, val, off});
            model[sig] = val;
        end
    endtask

    function automatic logic [31:0] wr_word(int k);
        logic [4:0]  a;
        logic [15:0] dv;
        case (k)
            0: begin a = 5'h00; dv = 16'h5027; end
            1: begin a = 5'h02; dv = 16'h6D18; end
            2: begin a = 5'h06; dv = 16'h8828; end
            3: begin a = 5'h07; dv = 16'h30FF; end
            4: begin a = 5'h08; dv = 16'h18D7; end
            5: begin a = 5'h0A; dv = 16'h00E9; end
            6: begin a = 5'h0B; dv = 16'h0511; end
            7: begin a = 5'h0D; dv = 16'h15B6; end
            8: begin a = 5'h0F; dv = 16'h0F0F; end
            9: begin a = 5'h05; dv = 16'h0BCB; end
            default: begin a = 5'h06; dv = 16'h8128; end
        endcase
        return {dv, 3'b000, a, 7'b0, 1'b1};
    endfunction

    function automatic void sample(ref logic [31:0] o[8]);
        o[0] = {31'b0, clk_en_o};
        o[1] = {28'b0, mdio_ctl_o};
        o[2] = {24'b0, phy_rst_o};
        o[3] = {31'b0, perst_n_o};
        o[4] = mdio_wr_o ? mdio_cmd_o : 32'h0;
        o[5] = {31'b0, done_o};
        o[6] = {31'b0, link_up_o};
        o[7] = {31'b0, timeout_o};
    endfunction

    // Monitor: compares each observed output change against the scoreboard.
    always @(negedge clk) begin
        if (mon_en) begin
            logic [31:0] now_v[8];
            sample(now_v);
            for (int s = 0; s < 8; s++) begin
                bit ev;
                ev = (s == 4) ? (now_v[4] != 32'h0) : (now_v[s] !== prev[s]);
                if (ev) begin
                    checks++;
                    if (exp_q.size() == 0) begin
                        errors++;
                        $display("FAIL %s unexpected change sig=%0d actual=%h at off=%0d expected none",
                                 req_of(s), s, now_v[s], cyc - base);
                    end else begin
                        ev_t e;
                        e = exp_q.pop_front();
                        if (e.sig != s || e.val !== now_v[s] || e.off != cyc - base) begin
                            errors++;
                            $display("FAIL %s actual sig=%0d val=%h off=%0d expected sig=%0d val=%h off=%0d",
                                     req_of(e.sig), s, now_v[s], cyc - base, e.sig, e.val, e.off);
                        end
                    end
                end
                prev[s] = now_v[s];
            end
        end
    end

    task automatic wait_off(int off);
        while (cyc - base < off) @(negedge clk);
    endtask

    // Driver: plans the expected events of one run, starts it, steers the link state.
    // link_try < 0 means the link never comes up (timeout).
    task automatic run(bit opt, int link_try, logic [5:0] good, logic [5:0] bad, bit poke);
        int a, pst, d0, last;
        a   = opt ? 3 : 0;
        pst = opt ? 211 * T + 16 : 200 * T + 2;
        d0  = pst + 1400 * T + 5;
        push(0, 1, 0);
        push(5, 0, 0); push(6, 0, 0); push(7, 0, 0);
        if (opt) begin
            push(1, 32'h8, 100 * T + 1);
            push(1, 32'h9, 100 * T + 2);
            push(1, 32'hB, 100 * T + 3);
        end
        push(2, 32'h01, 100 * T + 1 + a);
        push(2, 32'h81, 100 * T + 2 + a);
        if (opt)
            for (int k = 0; k < 11; k++) push(4, wr_word(k), 200 * T + 6 + k * (T + 1));
        push(3, 0, pst + 1);
        push(3, 1, pst + 300 * T + 2);
        push(2, 32'h01, pst + 300 * T + 3);
        push(2, 32'h81, pst + 300 * T + 4);
        if (link_try >= 0) begin
            last = d0 + link_try * (100 * T + 1);
            push(5, 1, last); push(6, 1, last);
        end else begin
            last = d0 + (TRIES - 1) * (100 * T + 1);
            push(5, 1, last); push(7, 1, last);
        end
        sel_i   = opt;
        ltssm_i = (link_try == 0) ? good : bad;
        @(negedge clk);
        start_i = 1'b1;
        base    = cyc + 1;
        @(negedge clk);
        start_i = 1'b0;
        sel_i   = ~opt;
        if (poke) begin // R10: start mid-run must not disturb anything
            wait_off(150 * T);
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        if (link_try > 0) begin
            wait_off(d0 + (link_try - 1) * (100 * T + 1) + 5);
            ltssm_i = good;
        end
        wait_off(last + 6);
        check("R11 scoreboard drained", exp_q.size(), 0);
        check("R10 done held in idle", {31'b0, done_o}, 1);
        check("R10 link flag held", {31'b0, link_up_o}, (link_try >= 0) ? 1 : 0);
        check("R10 timeout flag held", {31'b0, timeout_o}, (link_try >= 0) ? 0 : 1);
    endtask

    initial begin
        for (int s = 0; s < 8; s++) model[s] = 32'h0;
        model[3] = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 clk_en", {31'b0, clk_en_o}, 0);
        check("R1 mdio_ctl", {28'b0, mdio_ctl_o}, 0);
        check("R1 phy_rst", {24'b0, phy_rst_o}, 0);
        check("R1 perst_n", {31'b0, perst_n_o}, 0);
        check("R1 wr/cmd", {31'b0, mdio_wr_o} | mdio_cmd_o, 0);
        check("R1 flags", {29'b0, done_o, link_up_o, timeout_o}, 0);
        sample(prev);
        mon_en = 1'b1;
        run(1'b1, 0, 6'h11, 6'h00, 1'b1);   // R3 R5: full preload path, R10 mid-run start
        run(1'b0, 0, 6'h31, 6'h00, 1'b0);   // R6 skip path, R8 upper bits ignored
        run(1'b0, 3, 6'h11, 6'h0F, 1'b0);   // R9 link on fourth poll
        run(1'b1, -1, 6'h11, 6'h10, 1'b0);  // R9 timeout, R7 second PERST cycle
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule